// File: doc/BRIEF.md
# Shared Mailbox with Ownership Handoff

This block is a 256-bit register file, held as eight 32-bit dwords, that a requester port and a responder port share for exchanging one message at a time. A single flag decides which side may write. The flag lives in the top bit of the last dword (the control header). The requester fills the payload dwords and then writes the header dword. That write rings the doorbell and passes ownership to the responder. The responder writes its reply and its own header dword, which hands ownership back.

Each port has a 3-bit dword index, a write strobe and write data. Writes are registered in one cycle. Read data is combinational from the index on the same port. A function-reset input makes both read ports return all ones while it is high and leaves the stored contents alone. The block does not interpret the payload or the header fields.

Top module: `shared_mailbox`

## Requirements
- R1: Each port addresses eight dwords with a 3-bit index. A write that is accepted in a cycle shows on both read ports at that index from the next cycle. Reads are combinational from the port's own index.
- R2: A requester write to dword 7 while the requester owns the mailbox stores the data with bit 31 forced to 1. From the next cycle the responder owns the mailbox.
- R3: A responder write to dword 7 while the responder owns the mailbox stores the data with bit 31 forced to 0. From the next cycle the requester owns the mailbox.
- R4: While the responder owns the mailbox, requester writes to any dword have no effect on contents or ownership.
- R5: While the requester owns the mailbox, responder writes to any dword have no effect on contents or ownership.
- R6: While the function-reset input is high, both read ports return 0xFFFFFFFF at every index. Stored contents are kept and read back once the input falls.
- R7: A synchronous active-low global reset clears all dwords to zero and gives ownership to the requester.
- R8: The owner output equals bit 31 of dword 7 (1 = responder owns, 0 = requester owns).
- R9: Bits 30:0 of dword 7 are stored exactly as written. This covers the header fields: message type in bits 2:0, version in bits 5:3, direction in bit 7, status in bits 15:8 and the reset request in bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| fn_reset | input | 1 | Function reset in progress; forces all-ones reads |
| req_we | input | 1 | Requester write strobe |
| req_idx | input | 3 | Requester dword index (read and write) |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data |
| rsp_we | input | 1 | Responder write strobe |
| rsp_idx | input | 3 | Responder dword index (read and write) |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data |
| owner | output | 1 | 1 when the responder owns the mailbox |

## Verification
Both ports can write in the same cycle, including a doorbell on one side together with a write on the other. The bench sets this up in both directions. In one cycle the responder writes its header dword while the requester writes a payload dword. In another, the requester rings the doorbell while the responder writes a payload dword. Each cycle is judged against a bench model in which only the side that owned the mailbox before the edge takes effect. The function-reset override is also raised over live contents, to show that it masks reads only.

// File: rtl/mbx_pkg.sv
// Package: shared constants and the ownership encoding for the mailbox.
// Assumes a power-of-two dword count with the control header in the last dword.
package mbx_pkg;
    localparam int unsigned MBX_DWORDS = 8;
    localparam int unsigned MBX_DW     = 32;
    localparam int unsigned MBX_IDXW   = $clog2(MBX_DWORDS);

    typedef enum logic {
        OWN_REQ = 1'b0,
        OWN_RSP = 1'b1
    } owner_e;
endpackage

// File: rtl/mbx_gate.sv
// Module: write gating. Accepts a write only from the side that currently owns
// the mailbox, and flags writes to the header dword.
// Assumes the owner input is the registered flag, so it is stable within a cycle.
module mbx_gate #(
    parameter int unsigned IDXW = 3,
    parameter int unsigned LAST = 7
) (
    input  mbx_pkg::owner_e  owner,
    input  logic             req_we,
    input  logic [IDXW-1:0]  req_idx,
    input  logic             rsp_we,
    input  logic [IDXW-1:0]  rsp_idx,
    output logic             req_acc,
    output logic             rsp_acc,
    output logic             req_bell,
    output logic             rsp_release
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(LAST);

    // Purpose: each side writes only during its own ownership phase.
    always_comb begin
        req_acc     = req_we && (owner == mbx_pkg::OWN_REQ);
        rsp_acc     = rsp_we && (owner == mbx_pkg::OWN_RSP);
        req_bell    = req_acc && (req_idx == LAST_IDX);
        rsp_release = rsp_acc && (rsp_idx == LAST_IDX);
    end
endmodule

// File: rtl/mbx_store.sv
// Module: dword storage. One register per dword; the last dword's top bit is
// the ownership flag and is forced by whichever side writes that dword.
// Assumes at most one of req_acc / rsp_acc is high in any cycle.
module mbx_store #(
    parameter int unsigned DWORDS = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned IDXW   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_acc,
    input  logic [IDXW-1:0]         req_idx,
    input  logic [DW-1:0]           req_wdata,
    input  logic                    rsp_acc,
    input  logic [IDXW-1:0]         rsp_idx,
    input  logic [DW-1:0]           rsp_wdata,
    output logic [DWORDS-1:0][DW-1:0] words,
    output mbx_pkg::owner_e         owner
);
    localparam int unsigned LAST = DWORDS - 1;
    localparam int unsigned FLAG = DW - 1;

    for (genvar g = 0; g < DWORDS; g++) begin : g_dw
        localparam logic [IDXW-1:0] MY_IDX = IDXW'(g);
        logic req_hit;
        logic rsp_hit;

        // Purpose: decode whether this dword is addressed by an accepted write.
        always_comb begin
            req_hit = req_acc && (req_idx == MY_IDX);
            rsp_hit = rsp_acc && (rsp_idx == MY_IDX);
        end

        if (g == LAST) begin : g_hdr
            // Purpose: header dword; requester write sets the flag, responder write clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words[g] <= '0;
                end else if (req_hit) begin
                    words[g] <= {1'b1, req_wdata[FLAG-1:0]};
                end else if (rsp_hit) begin
                    words[g] <= {1'b0, rsp_wdata[FLAG-1:0]};
                end
            end
        end else begin : g_pay
            // Purpose: payload dword; stores whichever accepted write targets it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words[g] <= '0;
                end else if (req_hit) begin
                    words[g] <= req_wdata;
                end else if (rsp_hit) begin
                    words[g] <= rsp_wdata;
                end
            end
        end
    end

    // Purpose: expose the ownership flag held in the header dword.
    always_comb owner = mbx_pkg::owner_e'(words[LAST][FLAG]);
endmodule

// File: rtl/mbx_read.sv
// Module: one read port. Selects a dword by index and replaces it with all ones
// while the function reset is held.
// Assumes the index is within range (power-of-two dword count).
module mbx_read #(
    parameter int unsigned DWORDS = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned IDXW   = 3
) (
    input  logic [DWORDS-1:0][DW-1:0] words,
    input  logic [IDXW-1:0]           idx,
    input  logic                      fn_reset,
    output logic [DW-1:0]             rdata
);
    // Purpose: combinational select with the reset-state override.
    always_comb begin
        if (fn_reset) begin
            rdata = '1;
        end else begin
            rdata = words[idx];
        end
    end
endmodule

// File: rtl/shared_mailbox.sv
// Module: top of the shared mailbox. Joins the ownership gate, the dword store
// and two read ports. Assumes both ports share clk and the synchronous reset.
module shared_mailbox #(
    parameter int unsigned DWORDS = mbx_pkg::MBX_DWORDS,
    parameter int unsigned DW     = mbx_pkg::MBX_DW,
    parameter int unsigned IDXW   = $clog2(DWORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fn_reset,
    input  logic            req_we,
    input  logic [IDXW-1:0] req_idx,
    input  logic [DW-1:0]   req_wdata,
    output logic [DW-1:0]   req_rdata,
    input  logic            rsp_we,
    input  logic [IDXW-1:0] rsp_idx,
    input  logic [DW-1:0]   rsp_wdata,
    output logic [DW-1:0]   rsp_rdata,
    output logic            owner
);
    localparam int unsigned LAST = DWORDS - 1;

    logic [DWORDS-1:0][DW-1:0] words;
    mbx_pkg::owner_e           own_q;
    logic                      req_acc;
    logic                      rsp_acc;
    logic                      req_bell;
    logic                      rsp_release;

    mbx_gate #(.IDXW(IDXW), .LAST(LAST)) u_gate (
        .owner       (own_q),
        .req_we      (req_we),
        .req_idx     (req_idx),
        .rsp_we      (rsp_we),
        .rsp_idx     (rsp_idx),
        .req_acc     (req_acc),
        .rsp_acc     (rsp_acc),
        .req_bell    (req_bell),
        .rsp_release (rsp_release)
    );

    mbx_store #(.DWORDS(DWORDS), .DW(DW), .IDXW(IDXW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_acc   (req_acc),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .rsp_acc   (rsp_acc),
        .rsp_idx   (rsp_idx),
        .rsp_wdata (rsp_wdata),
        .words     (words),
        .owner     (own_q)
    );

    mbx_read #(.DWORDS(DWORDS), .DW(DW), .IDXW(IDXW)) u_rd_req (
        .words    (words),
        .idx      (req_idx),
        .fn_reset (fn_reset),
        .rdata    (req_rdata)
    );

    mbx_read #(.DWORDS(DWORDS), .DW(DW), .IDXW(IDXW)) u_rd_rsp (
        .words    (words),
        .idx      (rsp_idx),
        .fn_reset (fn_reset),
        .rdata    (rsp_rdata)
    );

    // Purpose: drive the ownership output from the stored flag.
    always_comb owner = (own_q == mbx_pkg::OWN_RSP);
endmodule

// File: rtl/shared_mailbox_chk.sv
// Module: property checker for the shared mailbox, bound to the top.
// Assumes it observes the top's ports only.
module shared_mailbox_chk #(
    parameter int unsigned DW   = 32,
    parameter int unsigned IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fn_reset,
    input logic            req_we,
    input logic [IDXW-1:0] req_idx,
    input logic [DW-1:0]   req_rdata,
    input logic            rsp_we,
    input logic [IDXW-1:0] rsp_idx,
    input logic [DW-1:0]   rsp_rdata,
    input logic            owner
);
    localparam logic [IDXW-1:0] HDR = '1;

    assert_doorbell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner && req_we && req_idx == HDR) |=> owner);

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner && rsp_we && rsp_idx == HDR) |=> !owner);

    assert_hold_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner && !(rsp_we && rsp_idx == HDR)) |=> owner);

    assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner && !(req_we && req_idx == HDR)) |=> !owner);

    assert_fn_reset_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fn_reset |-> (req_rdata == '1 && rsp_rdata == '1));

    assert_reset_owner_R7: assert property (@(posedge clk)
        !rst_n |=> !owner);

    assert_owner_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_reset && req_idx == HDR) |-> (req_rdata[DW-1] == owner));
endmodule

bind shared_mailbox shared_mailbox_chk #(.DW(DW), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fn_reset  (fn_reset),
    .req_we    (req_we),
    .req_idx   (req_idx),
    .req_rdata (req_rdata),
    .rsp_we    (rsp_we),
    .rsp_idx   (rsp_idx),
    .rsp_rdata (rsp_rdata),
    .owner     (owner)
);

// File: tb/shared_mailbox_bench.sv
module shared_mailbox_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fn_reset = 1'b0;
    logic        req_we = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        rsp_we = 1'b0;
    logic [2:0]  rsp_idx = '0;
    logic [31:0] rsp_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        owner;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] m [8];

    shared_mailbox u_shared_mailbox (
        .clk(clk), .rst_n(rst_n), .fn_reset(fn_reset),
        .req_we(req_we), .req_idx(req_idx), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
        .owner(owner)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock with optional writes on both ports; the model applies the rules.
    task automatic cyc(input logic rwe, input logic [2:0] ri, input logic [31:0] rd,
                       input logic swe, input logic [2:0] si, input logic [31:0] sd);
        logic was_rsp;
        @(negedge clk);
        req_we = rwe; req_idx = ri; req_wdata = rd;
        rsp_we = swe; rsp_idx = si; rsp_wdata = sd;
        @(posedge clk);
        was_rsp = m[7][31];
        if (!was_rsp && rwe) begin
            m[ri] = rd;
            if (ri == 3'd7) m[7][31] = 1'b1;
        end
        if (was_rsp && swe) begin
            m[si] = sd;
            if (si == 3'd7) m[7][31] = 1'b0;
        end
        #1;
        req_we = 1'b0; rsp_we = 1'b0;
    endtask

    // Read every dword on both ports and the owner flag.
    task automatic verify(input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_idx = 3'(i); rsp_idx = 3'(7 - i);
            #1;
            chk({tag, " req"}, req_rdata, fn_reset ? 32'hFFFF_FFFF : m[i]);
            chk({tag, " rsp"}, rsp_rdata, fn_reset ? 32'hFFFF_FFFF : m[7 - i]);
        end
        chk("R8 owner", {31'b0, owner}, {31'b0, m[7][31]});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) m[i] = '0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    function automatic logic [31:0] pat(input int i, input int s);
        return 32'(i * 32'h1357_9BDF + s * 32'h0F0F_1234) ^ 32'hA5A5_0000;
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) m[i] = '0;
        do_reset();
        verify("R7 reset state");

        // R1: requester fills payload dwords, readback on both ports
        for (int i = 0; i < 7; i++) cyc(1'b1, 3'(i), pat(i, 1), 1'b0, 3'd0, '0);
        verify("R1 requester fill");

        // R5: responder writes every dword while requester owns: ignored
        for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, '0, 1'b1, 3'(i), pat(i, 9));
        verify("R5 responder ignored");

        // R2/R9: doorbell with header type 1, ver 0, dir 0, reset flag bit 24, bit31 written 0
        cyc(1'b1, 3'd7, 32'h0100_0001, 1'b0, 3'd0, '0);
        verify("R2 doorbell");
        chk("R9 header kept", req_rdata & 32'h7FFF_FFFF, 32'h0100_0001);

        // R4: requester writes every dword while responder owns: ignored
        for (int i = 0; i < 8; i++) cyc(1'b1, 3'(i), pat(i, 5), 1'b0, 3'd0, '0);
        verify("R4 requester ignored");

        // R1: responder rewrites payload
        for (int i = 0; i < 7; i++) cyc(1'b0, 3'd0, '0, 1'b1, 3'(i), pat(i, 3));
        verify("R1 responder fill");

        // R3 with simultaneous requester write (ignored); bit31 written 1, dir 1, status 0x5a, ver 5
        cyc(1'b1, 3'd3, 32'hDEAD_BEEF, 1'b1, 3'd7, 32'h8000_5AAA);
        verify("R3 release");
        @(negedge clk); req_idx = 3'd7; #1;
        chk("R9 response header", req_rdata, 32'h0000_5AAA);

        // R2 with simultaneous responder write (ignored)
        cyc(1'b1, 3'd7, 32'h7FFF_FFFF, 1'b1, 3'd2, 32'h1234_5678);
        verify("R2 doorbell collide");

        // R6: function reset masks reads, contents retained
        @(negedge clk); fn_reset = 1'b1;
        verify("R6 all ones");
        @(negedge clk); fn_reset = 1'b0;
        verify("R6 restored");

        // R7: global reset while responder owns
        do_reset();
        verify("R7 reset again");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule